// File: doc/BRIEF.md
# Runahead Mode Controller

This block decides when an in-order-retire core stops waiting on a long-latency load and keeps working speculatively instead. When a load at the head of the retire window misses in the second-level cache, the controller takes a snapshot of the architectural state. That snapshot includes the global branch-history value and the return-address-stack top pointer. The triggering load is retired at once with its destination marked invalid, and the core moves into speculative mode.

In speculative mode the controller keeps one invalid bit per architectural register. Any retiring instruction that reads an invalid register is poisoned and retires without executing. Its destination becomes invalid, and any valid write clears the bit again. Branch resolutions are filtered by the invalid status of their operands. No retirement becomes architecturally visible in this mode.

When the miss data returns, the controller restores the snapshot and flushes everything in flight in the same cycle. One cycle later it redirects fetch to the load that started the episode.

Top module: `runahead_ctrl`

## Requirements
- R1: After reset the block is in normal mode, every invalid bit is 0, and ckpt_take, restore, flush_all, flush_young and redirect_valid are 0.
- R2: In normal mode, a valid head with rh_is_load=1 and rh_l2_miss=1 raises ckpt_take in that cycle. The head retires in that cycle with rh_poison=1 and rh_commit=0. From the next cycle mode_ahead=1, and if rh_dst_we=1, bit rh_dst of inv_vec is 1.
- R3: cur_hist and cur_ras_tos are captured in the ckpt_take cycle. They appear on restore_hist and restore_ras_tos in the restore cycle.
- R4: In speculative mode, a valid head retires (rh_retire=1). It is poisoned (rh_poison=1) when a used source has its invalid bit set or when it is a missing load. With rh_dst_we=1, bit rh_dst of inv_vec becomes the poison value from the next cycle.
- R5: In speculative mode, an instruction that retires unpoisoned with rh_dst_we=1 clears the invalid bit of its destination from the next cycle.
- R6: rh_commit is 0 in every cycle in which mode_ahead=1.
- R7: A missing load in speculative mode raises no ckpt_take. The saved restart address and snapshot are unchanged.
- R8: In speculative mode, a branch whose br_src_a or br_src_b register is invalid causes no flush_young and no redirect, even when br_mispred=1.
- R9: A branch with valid operands and br_mispred=1 raises flush_young and redirect_valid in the same cycle, with redirect_pc=br_target. When br_mispred=0 it causes neither.
- R10: miss_return in speculative mode raises restore and flush_all in the same cycle. In that cycle rh_retire is 0 and a branch is ignored. In the next cycle mode_ahead=0 and inv_vec=0, and redirect_valid=1 with redirect_pc equal to the triggering load's rh_pc. This refetch overrides a branch redirect in that cycle.
- R11: miss_return in normal mode has no effect: no restore and no redirect in the following cycle.
- R12: In normal mode, a valid head that is not a missing load retires with rh_poison=0, and rh_commit equals rh_dst_we.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| rh_valid | input | 1 | Instruction present at the retire head |
| rh_pc | input | PC_W | Address of the head instruction |
| rh_is_load | input | 1 | Head is a load |
| rh_l2_miss | input | 1 | Head load missed in the second-level cache |
| rh_dst_we | input | 1 | Head writes a destination register |
| rh_dst | input | REG_W | Destination register index |
| rh_src_a | input | REG_W | First source register index |
| rh_src_a_used | input | 1 | First source is read |
| rh_src_b | input | REG_W | Second source register index |
| rh_src_b_used | input | 1 | Second source is read |
| rh_retire | output | 1 | Head retires this cycle |
| rh_poison | output | 1 | Head retires without executing; destination invalid |
| rh_commit | output | 1 | Head result becomes architecturally visible |
| miss_return | input | 1 | Stalled load data has returned |
| br_valid | input | 1 | Branch resolution this cycle |
| br_src_a | input | REG_W | Branch operand register A |
| br_src_b | input | REG_W | Branch operand register B |
| br_mispred | input | 1 | Evaluation disagrees with the prediction |
| br_target | input | PC_W | Correct branch destination |
| cur_hist | input | GH_W | Live global branch history |
| cur_ras_tos | input | RAS_W | Live return-stack top pointer |
| ckpt_take | output | 1 | Snapshot the architectural state now |
| restore | output | 1 | Restore the snapshot now |
| flush_all | output | 1 | Flush every in-flight instruction |
| flush_young | output | 1 | Flush instructions younger than the branch |
| restore_hist | output | GH_W | Saved branch history |
| restore_ras_tos | output | RAS_W | Saved return-stack top pointer |
| redirect_valid | output | 1 | Redirect fetch this cycle |
| redirect_pc | output | PC_W | Fetch redirect address |
| mode_ahead | output | 1 | 1 in speculative mode |
| inv_vec | output | NREG | Per-register invalid bits |

## Verification
The tightest interaction is the return cycle. There the miss return can coincide with a head retirement and a mispredicted branch. The cycle after it can coincide with another branch redirect or even a new triggering miss. Directed sequences force each of these pairings. The random phase also produces them by chance, because returns, branches and heads are drawn independently each cycle. A bench model judges each cycle with restore taking priority over retirement and branches, and the pending refetch taking priority over a branch redirect. The model also checks that the invalid vector reads zero straight after the return.

// File: rtl/ra_pkg.sv
// Package: shared types for the runahead mode controller.
// Assumes: nothing beyond IEEE 1800-2017.
package ra_pkg;
    typedef enum logic [0:0] {
        MODE_NORMAL = 1'b0,
        MODE_AHEAD  = 1'b1
    } ra_mode_e;
endpackage

// File: rtl/ra_mode_fsm.sv
// Module: ra_mode_fsm
// Holds the normal/speculative mode, the restart address and the saved
// history snapshot. Drives the checkpoint and restore strobes, and the
// one-cycle-late refetch request.
// Assumes: `enter` is only meaningful for a valid missing load at the head;
// a return strobe outside speculative mode is ignored.
module ra_mode_fsm
    import ra_pkg::*;
#(
    parameter int PC_W  = 32,
    parameter int GH_W  = 12,
    parameter int RAS_W = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             enter,
    input  logic             ret_strobe,
    input  logic [PC_W-1:0]  trig_pc,
    input  logic [GH_W-1:0]  hist_in,
    input  logic [RAS_W-1:0] ras_in,
    output logic             ahead,
    output logic             ckpt_take,
    output logic             restore,
    output logic             refetch_valid,
    output logic [PC_W-1:0]  refetch_pc,
    output logic [GH_W-1:0]  hist_out,
    output logic [RAS_W-1:0] ras_out
);
    ra_mode_e         mode_q;
    logic [PC_W-1:0]  pc_q;
    logic [GH_W-1:0]  hist_q;
    logic [RAS_W-1:0] ras_q;
    logic             refetch_q;

    // Purpose: decode the mode-change strobes for this cycle.
    always_comb begin
        ahead     = (mode_q == MODE_AHEAD);
        ckpt_take = !ahead && enter;
        restore   = ahead && ret_strobe;
    end

    // Purpose: advance the mode and arm the refetch after a restore.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mode_q    <= MODE_NORMAL;
            refetch_q <= 1'b0;
        end else begin
            refetch_q <= restore;
            if (restore)
                mode_q <= MODE_NORMAL;
            else if (ckpt_take)
                mode_q <= MODE_AHEAD;
        end
    end

    // Purpose: capture the restart address and snapshot on entry only.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pc_q   <= '0;
            hist_q <= '0;
            ras_q  <= '0;
        end else if (ckpt_take) begin
            pc_q   <= trig_pc;
            hist_q <= hist_in;
            ras_q  <= ras_in;
        end
    end

    assign refetch_valid = refetch_q;
    assign refetch_pc    = pc_q;
    assign hist_out      = hist_q;
    assign ras_out       = ras_q;
endmodule

// File: rtl/ra_inv_tracker.sv
// Module: ra_inv_tracker
// One invalid bit per architectural register. Computes the poison status
// of the retire head and the invalid status of the branch operands.
// Assumes: the caller gates wr_en so that writes happen only for retiring
// instructions that touch speculative state; clear_all wins over a write.
module ra_inv_tracker #(
    parameter int NREG  = 16,
    parameter int REG_W = $clog2(NREG)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clear_all,
    input  logic             wr_en,
    input  logic [REG_W-1:0] wr_idx,
    input  logic             wr_inv,
    input  logic [REG_W-1:0] src_a,
    input  logic             src_a_used,
    input  logic [REG_W-1:0] src_b,
    input  logic             src_b_used,
    input  logic             head_miss_load,
    input  logic [REG_W-1:0] br_a,
    input  logic [REG_W-1:0] br_b,
    output logic             head_poison,
    output logic             br_inv,
    output logic [NREG-1:0]  inv_vec
);
    logic [NREG-1:0] inv_q;

    // Purpose: one flop per register, cleared on restore, written on retire.
    for (genvar g = 0; g < NREG; g++) begin : g_inv
        always_ff @(posedge clk) begin
            if (!rst_n || clear_all)
                inv_q[g] <= 1'b0;
            else if (wr_en && (wr_idx == REG_W'(g)))
                inv_q[g] <= wr_inv;
        end
    end

    // Purpose: poison the head on an invalid source or a missing load.
    always_comb begin
        head_poison = (src_a_used && inv_q[src_a])
                   || (src_b_used && inv_q[src_b])
                   || head_miss_load;
        br_inv      = inv_q[br_a] || inv_q[br_b];
    end

    assign inv_vec = inv_q;
endmodule

// File: rtl/ra_branch_unit.sv
// Module: ra_branch_unit
// Filters branch resolutions: a branch that depends on an invalid operand
// keeps its prediction; a branch with valid operands that mispredicted
// flushes younger work and redirects fetch.
// Assumes: `suppress` is high in cycles owned by restore or refetch.
module ra_branch_unit #(
    parameter int PC_W = 32
) (
    input  logic            br_valid,
    input  logic            br_mispred,
    input  logic [PC_W-1:0] br_target,
    input  logic            br_inv,
    input  logic            suppress,
    output logic            flush_young,
    output logic            br_redirect,
    output logic [PC_W-1:0] br_pc
);
    // Purpose: decide whether this resolution acts on the pipeline.
    always_comb begin
        flush_young = br_valid && br_mispred && !br_inv && !suppress;
        br_redirect = flush_young;
        br_pc       = br_target;
    end
endmodule

// File: rtl/runahead_ctrl.sv
// Module: runahead_ctrl (top)
// Mode controller for a core that runs ahead past a second-level miss.
// Ties the mode FSM, the invalid-bit tracker and the branch filter, and
// drives retire, commit and fetch-redirect decisions.
// Assumes: one retire-head instruction and one branch resolution per cycle;
// snapshot storage for the register file lives outside and follows
// ckpt_take/restore.
module runahead_ctrl #(
    parameter int NREG  = 16,
    parameter int PC_W  = 32,
    parameter int GH_W  = 12,
    parameter int RAS_W = 4,
    parameter int REG_W = $clog2(NREG)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             rh_valid,
    input  logic [PC_W-1:0]  rh_pc,
    input  logic             rh_is_load,
    input  logic             rh_l2_miss,
    input  logic             rh_dst_we,
    input  logic [REG_W-1:0] rh_dst,
    input  logic [REG_W-1:0] rh_src_a,
    input  logic             rh_src_a_used,
    input  logic [REG_W-1:0] rh_src_b,
    input  logic             rh_src_b_used,
    output logic             rh_retire,
    output logic             rh_poison,
    output logic             rh_commit,
    input  logic             miss_return,
    input  logic             br_valid,
    input  logic [REG_W-1:0] br_src_a,
    input  logic [REG_W-1:0] br_src_b,
    input  logic             br_mispred,
    input  logic [PC_W-1:0]  br_target,
    input  logic [GH_W-1:0]  cur_hist,
    input  logic [RAS_W-1:0] cur_ras_tos,
    output logic             ckpt_take,
    output logic             restore,
    output logic             flush_all,
    output logic             flush_young,
    output logic [GH_W-1:0]  restore_hist,
    output logic [RAS_W-1:0] restore_ras_tos,
    output logic             redirect_valid,
    output logic [PC_W-1:0]  redirect_pc,
    output logic             mode_ahead,
    output logic [NREG-1:0]  inv_vec
);
    logic            head_miss;
    logic            head_poison;
    logic            br_inv;
    logic            inv_wr_en;
    logic            refetch_valid;
    logic [PC_W-1:0] refetch_pc;
    logic            br_redirect;
    logic [PC_W-1:0] br_pc;

    // Purpose: identify a missing load at the head.
    assign head_miss = rh_valid && rh_is_load && rh_l2_miss;

    ra_mode_fsm #(
        .PC_W (PC_W),
        .GH_W (GH_W),
        .RAS_W(RAS_W)
    ) u_fsm (
        .clk          (clk),
        .rst_n        (rst_n),
        .enter        (head_miss),
        .ret_strobe   (miss_return),
        .trig_pc      (rh_pc),
        .hist_in      (cur_hist),
        .ras_in       (cur_ras_tos),
        .ahead        (mode_ahead),
        .ckpt_take    (ckpt_take),
        .restore      (restore),
        .refetch_valid(refetch_valid),
        .refetch_pc   (refetch_pc),
        .hist_out     (restore_hist),
        .ras_out      (restore_ras_tos)
    );

    // Purpose: retire decisions; restore flushes the head, so it never retires.
    always_comb begin
        rh_retire = rh_valid && !restore;
        rh_poison = rh_retire && head_poison;
        rh_commit = rh_retire && !mode_ahead && !head_poison && rh_dst_we;
        inv_wr_en = rh_retire && rh_dst_we && (mode_ahead || ckpt_take);
        flush_all = restore;
    end

    ra_inv_tracker #(
        .NREG (NREG),
        .REG_W(REG_W)
    ) u_inv (
        .clk           (clk),
        .rst_n         (rst_n),
        .clear_all     (restore),
        .wr_en         (inv_wr_en),
        .wr_idx        (rh_dst),
        .wr_inv        (head_poison),
        .src_a         (rh_src_a),
        .src_a_used    (rh_src_a_used),
        .src_b         (rh_src_b),
        .src_b_used    (rh_src_b_used),
        .head_miss_load(head_miss),
        .br_a          (br_src_a),
        .br_b          (br_src_b),
        .head_poison   (head_poison),
        .br_inv        (br_inv),
        .inv_vec       (inv_vec)
    );

    ra_branch_unit #(
        .PC_W(PC_W)
    ) u_br (
        .br_valid   (br_valid),
        .br_mispred (br_mispred),
        .br_target  (br_target),
        .br_inv     (br_inv),
        .suppress   (restore || refetch_valid),
        .flush_young(flush_young),
        .br_redirect(br_redirect),
        .br_pc      (br_pc)
    );

    // Purpose: the refetch after a restore takes the redirect port first.
    always_comb begin
        redirect_valid = refetch_valid || br_redirect;
        redirect_pc    = refetch_valid ? refetch_pc : br_pc;
    end
endmodule

// File: rtl/ra_ctrl_checker.sv
// Module: ra_ctrl_checker
// Temporal properties of runahead_ctrl, bound to every instance.
// Assumes: synchronous active-low reset; keeps its own copy of the
// triggering address so the refetch target is checked independently.
module ra_ctrl_checker #(
    parameter int NREG  = 16,
    parameter int PC_W  = 32,
    parameter int REG_W = $clog2(NREG)
) (
    input logic             clk,
    input logic             rst_n,
    input logic             rh_valid,
    input logic [PC_W-1:0]  rh_pc,
    input logic             rh_retire,
    input logic             rh_commit,
    input logic             miss_return,
    input logic             br_valid,
    input logic [REG_W-1:0] br_src_a,
    input logic [REG_W-1:0] br_src_b,
    input logic             ckpt_take,
    input logic             restore,
    input logic             flush_all,
    input logic             flush_young,
    input logic             redirect_valid,
    input logic [PC_W-1:0]  redirect_pc,
    input logic             mode_ahead,
    input logic [NREG-1:0]  inv_vec
);
    logic [PC_W-1:0] seen_pc;

    // Purpose: remember the head address at each checkpoint.
    always_ff @(posedge clk) begin
        if (!rst_n)
            seen_pc <= '0;
        else if (ckpt_take && rh_valid)
            seen_pc <= rh_pc;
    end

    p_no_commit_ahead_r6: assert property (@(posedge clk) disable iff (!rst_n)
        mode_ahead |-> !rh_commit);

    p_enter_mode_r2: assert property (@(posedge clk) disable iff (!rst_n)
        ckpt_take |=> mode_ahead);

    p_single_ckpt_r7: assert property (@(posedge clk) disable iff (!rst_n)
        mode_ahead |-> !ckpt_take);

    p_restore_flush_r10: assert property (@(posedge clk) disable iff (!rst_n)
        restore |-> (flush_all && !rh_retire && !flush_young));

    p_refetch_r10: assert property (@(posedge clk) disable iff (!rst_n)
        restore |=> (redirect_valid && (redirect_pc == seen_pc)
                     && !mode_ahead && (inv_vec == '0)));

    p_inv_branch_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (br_valid && mode_ahead && (inv_vec[br_src_a] || inv_vec[br_src_b]))
            |-> !flush_young);

    p_return_normal_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (miss_return && !mode_ahead) |-> !restore);

    p_clean_normal_r1: assert property (@(posedge clk) disable iff (!rst_n)
        !mode_ahead |-> (inv_vec == '0));
endmodule

bind runahead_ctrl ra_ctrl_checker #(
    .NREG (NREG),
    .PC_W (PC_W),
    .REG_W(REG_W)
) u_ra_chk (
    .clk           (clk),
    .rst_n         (rst_n),
    .rh_valid      (rh_valid),
    .rh_pc         (rh_pc),
    .rh_retire     (rh_retire),
    .rh_commit     (rh_commit),
    .miss_return   (miss_return),
    .br_valid      (br_valid),
    .br_src_a      (br_src_a),
    .br_src_b      (br_src_b),
    .ckpt_take     (ckpt_take),
    .restore       (restore),
    .flush_all     (flush_all),
    .flush_young   (flush_young),
    .redirect_valid(redirect_valid),
    .redirect_pc   (redirect_pc),
    .mode_ahead    (mode_ahead),
    .inv_vec       (inv_vec)
);

// File: tb/test_runahead_ctrl.sv
`timescale 1ns/1ps
module test_runahead_ctrl;
    localparam int NREG = 16, PC_W = 32, GH_W = 12, RAS_W = 4, REG_W = 4;

    logic clk = 1'b0, rst_n = 1'b0;
    logic rh_valid, rh_is_load, rh_l2_miss, rh_dst_we, rh_src_a_used, rh_src_b_used;
    logic [PC_W-1:0] rh_pc, br_target;
    logic [REG_W-1:0] rh_dst, rh_src_a, rh_src_b, br_src_a, br_src_b;
    logic miss_return, br_valid, br_mispred;
    logic [GH_W-1:0] cur_hist;
    logic [RAS_W-1:0] cur_ras_tos;
    logic rh_retire, rh_poison, rh_commit, ckpt_take, restore, flush_all, flush_young;
    logic [GH_W-1:0] restore_hist;
    logic [RAS_W-1:0] restore_ras_tos;
    logic redirect_valid, mode_ahead;
    logic [PC_W-1:0] redirect_pc;
    logic [NREG-1:0] inv_vec;

    int checks = 0, errors = 0;

    // bench model state
    logic m_ahead = 1'b0, m_refetch = 1'b0;
    logic [NREG-1:0] m_inv = '0;
    logic [PC_W-1:0] m_pc = '0;
    logic [GH_W-1:0] m_hist = '0;
    logic [RAS_W-1:0] m_ras = '0;

    always #2.5 clk = ~clk;

    runahead_ctrl i_runahead_ctrl (.*);

    task automatic chk(input string req, input string what, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    task automatic idle_inputs();
        rh_valid = 0; rh_is_load = 0; rh_l2_miss = 0; rh_dst_we = 0;
        rh_src_a_used = 0; rh_src_b_used = 0; rh_pc = '0; rh_dst = '0;
        rh_src_a = '0; rh_src_b = '0; miss_return = 0; br_valid = 0;
        br_mispred = 0; br_target = '0; br_src_a = '0; br_src_b = '0;
        cur_hist = '0; cur_ras_tos = '0;
    endtask

    task automatic head(input logic ld, input logic miss, input logic we, input int d,
                        input int a, input logic au, input int b, input logic bu);
        rh_valid = 1; rh_is_load = ld; rh_l2_miss = miss; rh_dst_we = we;
        rh_dst = REG_W'(d); rh_src_a = REG_W'(a); rh_src_a_used = au;
        rh_src_b = REG_W'(b); rh_src_b_used = bu; rh_pc = $urandom;
    endtask

    task automatic branch(input int a, input int b, input logic mis);
        br_valid = 1; br_src_a = REG_W'(a); br_src_b = REG_W'(b);
        br_mispred = mis; br_target = $urandom;
    endtask

    // Check the outputs against the model, then advance the model at the edge.
    task automatic step();
        logic e_trig, e_rest, e_ret, e_pois, e_com, e_fy, e_rv;
        logic [PC_W-1:0] e_rpc;
        #1;
        e_trig = !m_ahead && rh_valid && rh_is_load && rh_l2_miss;
        e_rest = m_ahead && miss_return;
        e_ret  = rh_valid && !e_rest;
        e_pois = e_ret && ((rh_src_a_used && m_inv[rh_src_a]) || (rh_src_b_used && m_inv[rh_src_b])
                           || (rh_is_load && rh_l2_miss));
        e_com  = e_ret && !m_ahead && !e_pois && rh_dst_we;
        e_fy   = br_valid && br_mispred && !e_rest && !m_refetch && !(m_inv[br_src_a] || m_inv[br_src_b]);
        e_rv   = m_refetch || e_fy;
        e_rpc  = m_refetch ? m_pc : br_target;
        chk(m_ahead ? "R4" : "R12", "rh_retire", rh_retire, e_ret);
        chk(m_ahead ? "R4" : "R2/R12", "rh_poison", rh_poison, e_pois);
        chk("R6", "rh_commit", rh_commit, e_com);
        chk("R2/R7", "ckpt_take", ckpt_take, e_trig);
        chk("R10/R11", "restore", restore, e_rest);
        chk("R10", "flush_all", flush_all, e_rest);
        chk("R8/R9", "flush_young", flush_young, e_fy);
        chk("R9/R10", "redirect_valid", redirect_valid, e_rv);
        if (e_rv) chk("R9/R10", "redirect_pc", redirect_pc, e_rpc);
        chk("R2/R10", "mode_ahead", mode_ahead, m_ahead);
        chk("R4/R5", "inv_vec", inv_vec, m_inv);
        if (e_rest) begin
            chk("R3", "restore_hist", restore_hist, m_hist);
            chk("R3", "restore_ras_tos", restore_ras_tos, m_ras);
        end
        @(posedge clk);
        m_refetch = e_rest;
        if (e_rest) begin
            m_ahead = 0; m_inv = '0;
        end else begin
            if (e_ret && rh_dst_we && (m_ahead || e_trig)) m_inv[rh_dst] = e_pois;
            if (e_trig) begin
                m_ahead = 1; m_pc = rh_pc; m_hist = cur_hist; m_ras = cur_ras_tos;
            end
        end
        @(negedge clk);
        idle_inputs();
        cur_hist = GH_W'($urandom); cur_ras_tos = RAS_W'($urandom);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        errors++; checks++;
        $display("FAIL watchdog: actual=timeout expected=finish");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        void'($urandom(32'd20240611));
        idle_inputs();
        repeat (3) @(negedge clk);
        // R1 reset state
        chk("R1", "mode_ahead", mode_ahead, 1'b0);
        chk("R1", "inv_vec", inv_vec, '0);
        chk("R1", "ckpt_take", ckpt_take, 1'b0);
        chk("R1", "restore", restore, 1'b0);
        chk("R1", "flush_young", flush_young, 1'b0);
        chk("R1", "redirect_valid", redirect_valid, 1'b0);
        rst_n = 1;
        // R11: return strobe while normal
        miss_return = 1; step();
        step();
        // R12 plain retire, R9 correct prediction and mispredict
        head(0, 0, 1, 3, 1, 1, 2, 1); branch(1, 2, 0); step();
        head(1, 0, 1, 4, 1, 1, 0, 0); branch(1, 2, 1); step();
        // R2 trigger with snapshot (R3)
        cur_hist = 12'hA5C; cur_ras_tos = 4'h9;
        head(1, 1, 1, 5, 0, 0, 0, 0); step();
        // R4 propagate from r5 into r6, R5 clear r5 by immediate move
        head(0, 0, 1, 6, 5, 1, 1, 1); step();
        head(0, 0, 1, 5, 0, 0, 0, 0); step();
        // R7 second miss
        head(1, 1, 1, 7, 2, 1, 0, 0); step();
        // R8 branch on invalid operand, R9 valid mispredict in ahead mode
        branch(6, 1, 1); step();
        branch(1, 2, 1); head(0, 0, 1, 8, 7, 1, 0, 0); step();
        // R10 return coinciding with retire and branch, then branch vs refetch
        miss_return = 1; head(0, 0, 1, 9, 1, 1, 0, 0); branch(1, 2, 1); step();
        branch(3, 4, 1); head(1, 1, 1, 2, 0, 0, 0, 0); step();
        miss_return = 1; step();
        step();
        // random phase
        for (int i = 0; i < 4000; i++) begin
            if ($urandom_range(0, 3) != 0)
                head($urandom_range(0, 2) == 0, $urandom_range(0, 9) == 0, $urandom_range(0, 4) != 0,
                     $urandom_range(0, NREG-1), $urandom_range(0, NREG-1), $urandom_range(0, 1) == 1,
                     $urandom_range(0, NREG-1), $urandom_range(0, 1) == 1);
            if ($urandom_range(0, 2) == 0)
                branch($urandom_range(0, NREG-1), $urandom_range(0, NREG-1), $urandom_range(0, 2) == 0);
            miss_return = ($urandom_range(0, 24) == 0);
            step();
        end
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule